// File: doc/BRIEF.md
# Operand read request controller

This block sits beside a multi-operand computation unit and gathers its source operands. When an instruction is issued, it raises one read request per source operand that has to come from the register file. For each such operand it then waits for a single-cycle grant pulse from the register-file side and captures the value on that operand's slice of the source bus in the grant cycle. After the capture, the request drops.

Two operands can skip the register file. When the zero qualifier is sampled with issue, operand 0 is loaded with zero and never requests. When the immediate qualifier is sampled with issue, operand 1 is loaded with the immediate value and never requests. A ready flag goes high once every operand holds its value, whether captured or substituted. The flag clears on the next issue, unless that issue substitutes every operand.

Top module: `opread_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every `req_o` bit, `all_ready_o` and every operand slice of `opnd_o` are 0.
- R2: Until `issue_i` has been sampled high for the first time after reset, every `req_o` bit stays 0 and `all_ready_o` stays 0, whatever `go_i` does.
- R3: When `issue_i` is sampled high at a clock edge, each operand that is not substituted has its `req_o` bit high from the cycle after that edge.
- R4: When `zero_op_i` is sampled high together with `issue_i`, `req_o[0]` does not assert for that instruction and operand 0 (`opnd_o[DATA_W-1:0]`) is loaded with 0.
- R5: When `imm_valid_i` is sampled high together with `issue_i`, `req_o[1]` does not assert for that instruction and operand 1 is loaded with `imm_data_i`.
- R6: When `go_i[k]` is sampled high while `req_o[k]` is high, the operand is loaded with `src_data_i[k*DATA_W +: DATA_W]` as presented in that cycle, and `req_o[k]` is low from the next cycle until the next issue.
- R7: A `go_i[k]` pulse sampled while `req_o[k]` is low is ignored: operand k and `req_o[k]` keep their values.
- R8: `all_ready_o` is high in the cycle after the last outstanding operand is captured. While it is high, `req_o` is all zero. It clears after the next issue, unless that issue substitutes every operand.
- R9: An issue sampled while requests are outstanding restarts every operand. A `go_i` pulse sampled in the same cycle as `issue_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Instruction issue strobe |
| zero_op_i | input | 1 | Operand 0 forced to zero (sampled with issue) |
| imm_valid_i | input | 1 | Operand 1 taken from immediate (sampled with issue) |
| imm_data_i | input | DATA_W | Immediate value |
| go_i | input | NUM_OPS | Per-operand read grant pulses |
| src_data_i | input | NUM_OPS*DATA_W | Source bus, operand k at slice k |
| req_o | output | NUM_OPS | Per-operand read requests |
| opnd_o | output | NUM_OPS*DATA_W | Latched operands, operand k at slice k |
| all_ready_o | output | 1 | Every operand captured or substituted |

## Verification
The assertions check the following on every cycle:
- requests stay silent before the first issue;
- requests rise one cycle after an issue, per operand and according to the qualifiers;
- a qualified operand never requests;
- a granted request drops and captures the bus;
- a stray grant leaves the operand unchanged;
- readiness never coexists with an open request.

Only the bench's scenarios show these:
- the actual operand values after mixed sequences of grant order and substitution;
- readiness clearing on a re-issue;
- the restart that happens when an issue lands on half-collected operands together with a grant.

// File: rtl/opread_pkg.sv
package opread_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_ZERO    = 2'd1,
    SRC_IMM     = 2'd2
  } src_kind_e;

  // Where operand idx comes from, given the qualifiers sampled with issue.
  function automatic src_kind_e src_kind(input int idx, input logic zero_q, input logic imm_q);
    if (idx == 0 && zero_q) return SRC_ZERO;
    if (idx == 1 && imm_q)  return SRC_IMM;
    return SRC_REGFILE;
  endfunction

endpackage

// File: rtl/opread_slot.sv
module opread_slot
  import opread_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  src_kind_e         kind_i,
  input  logic              go_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic              req_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              capture_o,
  output logic              stray_go_o
);

  logic              pend_q, done_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] fill_val;

  always_comb begin
    case (kind_i)
      SRC_IMM:  fill_val = imm_i;
      default:  fill_val = '0;
    endcase
  end

  // Named events for the checker
  assign capture_o  = go_i & pend_q & ~issue_i;
  assign stray_go_o = go_i & ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else if (issue_i) begin
      pend_q <= (kind_i == SRC_REGFILE);
      done_q <= (kind_i != SRC_REGFILE);
      data_q <= fill_val;
    end else if (capture_o) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
      data_q <= src_i;
    end
  end

  assign req_o  = pend_q;
  assign done_o = done_q;
  assign data_o = data_q;

endmodule

// File: rtl/opread_ready.sv
module opread_ready #(
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0] done_i,
  output logic               all_ready_o
);
  assign all_ready_o = &done_i;
endmodule

// File: rtl/opread_ctrl.sv
module opread_ctrl
  import opread_pkg::*;
#(
  parameter int NUM_OPS = 2,
  parameter int DATA_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issue_i,
  input  logic                      zero_op_i,
  input  logic                      imm_valid_i,
  input  logic [DATA_W-1:0]         imm_data_i,
  input  logic [NUM_OPS-1:0]        go_i,
  input  logic [NUM_OPS*DATA_W-1:0] src_data_i,
  output logic [NUM_OPS-1:0]        req_o,
  output logic [NUM_OPS*DATA_W-1:0] opnd_o,
  output logic                      all_ready_o
);

  localparam int BUS_W = NUM_OPS * DATA_W;

  logic [NUM_OPS-1:0] done_vec;
  logic [NUM_OPS-1:0] capture_vec;
  logic [NUM_OPS-1:0] stray_vec;
  logic [BUS_W-1:0]   opnd_bus;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_slot
    src_kind_e kind;
    assign kind = src_kind(k, zero_op_i, imm_valid_i);

    opread_slot #(.DATA_W(DATA_W)) slot_i (
      .clk        (clk),
      .rst        (rst),
      .issue_i    (issue_i),
      .kind_i     (kind),
      .go_i       (go_i[k]),
      .src_i      (src_data_i[k*DATA_W +: DATA_W]),
      .imm_i      (imm_data_i),
      .req_o      (req_o[k]),
      .done_o     (done_vec[k]),
      .data_o     (opnd_bus[k*DATA_W +: DATA_W]),
      .capture_o  (capture_vec[k]),
      .stray_go_o (stray_vec[k])
    );
  end

  opread_ready #(.NUM_OPS(NUM_OPS)) ready_i (
    .done_i      (done_vec),
    .all_ready_o (all_ready_o)
  );

  assign opnd_o = opnd_bus;

endmodule

// File: rtl/opread_ctrl_chk.sv
module opread_ctrl_chk #(
  parameter int NUM_OPS = 2,
  parameter int DATA_W  = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      issue_i,
  input logic                      zero_op_i,
  input logic                      imm_valid_i,
  input logic [DATA_W-1:0]         imm_data_i,
  input logic [NUM_OPS-1:0]        go_i,
  input logic [NUM_OPS*DATA_W-1:0] src_data_i,
  input logic [NUM_OPS-1:0]        req_o,
  input logic [NUM_OPS*DATA_W-1:0] opnd_o,
  input logic                      all_ready_o,
  input logic [NUM_OPS-1:0]        capture_vec,
  input logic [NUM_OPS-1:0]        stray_vec
);

  logic seen_issue;
  always_ff @(posedge clk) begin
    if (rst) seen_issue <= 1'b0;
    else if (issue_i) seen_issue <= 1'b1;
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !seen_issue |-> (req_o == '0 && !all_ready_o));

  assert_ready_no_req_R8: assert property (@(posedge clk) disable iff (rst)
    all_ready_o |-> (req_o == '0));

  assert_zero_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_i && zero_op_i) |=> (!req_o[0] && opnd_o[DATA_W-1:0] == '0));

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
    if (k == 1) begin : g_imm
      assert_imm_no_req_R5: assert property (@(posedge clk) disable iff (rst)
        (issue_i && imm_valid_i) |=>
          (!req_o[1] && opnd_o[DATA_W +: DATA_W] == $past(imm_data_i)));
    end

    assert_req_after_issue_R3: assert property (@(posedge clk) disable iff (rst)
      (issue_i && !(k == 0 && zero_op_i) && !(k == 1 && imm_valid_i)) |=> req_o[k]);

    assert_capture_drop_R6: assert property (@(posedge clk) disable iff (rst)
      capture_vec[k] |=>
        (!req_o[k] && opnd_o[k*DATA_W +: DATA_W] == $past(src_data_i[k*DATA_W +: DATA_W])));

    assert_stray_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (stray_vec[k] && !issue_i) |=>
        ($stable(opnd_o[k*DATA_W +: DATA_W]) && !req_o[k]));

    assert_go_on_issue_R9: assert property (@(posedge clk) disable iff (rst)
      (issue_i && go_i[k] && !(k == 0 && zero_op_i) && !(k == 1 && imm_valid_i)) |=> req_o[k]);
  end

endmodule

bind opread_ctrl opread_ctrl_chk #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .issue_i(issue_i), .zero_op_i(zero_op_i),
  .imm_valid_i(imm_valid_i), .imm_data_i(imm_data_i), .go_i(go_i),
  .src_data_i(src_data_i), .req_o(req_o), .opnd_o(opnd_o),
  .all_ready_o(all_ready_o), .capture_vec(capture_vec), .stray_vec(stray_vec)
);

// File: tb/opread_ctrl_tb_top.sv
module opread_ctrl_tb_top;
  localparam int NUM_OPS = 2;
  localparam int DATA_W  = 64;

  logic                      clk = 1'b0;
  logic                      rst;
  logic                      issue_i, zero_op_i, imm_valid_i;
  logic [DATA_W-1:0]         imm_data_i;
  logic [NUM_OPS-1:0]        go_i;
  logic [NUM_OPS*DATA_W-1:0] src_data_i;
  logic [NUM_OPS-1:0]        req_o;
  logic [NUM_OPS*DATA_W-1:0] opnd_o;
  logic                      all_ready_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  opread_ctrl #(.NUM_OPS(NUM_OPS), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .issue_i(issue_i), .zero_op_i(zero_op_i),
    .imm_valid_i(imm_valid_i), .imm_data_i(imm_data_i), .go_i(go_i),
    .src_data_i(src_data_i), .req_o(req_o), .opnd_o(opnd_o),
    .all_ready_o(all_ready_o)
  );

  function automatic logic [DATA_W-1:0] op(input int k);
    return opnd_o[k*DATA_W +: DATA_W];
  endfunction

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All stimulus changes at the falling edge; results are read at the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_issue(input logic z, input logic im, input logic [DATA_W-1:0] iv,
                          input logic [NUM_OPS-1:0] g);
    issue_i = 1'b1; zero_op_i = z; imm_valid_i = im; imm_data_i = iv; go_i = g;
    src_data_i = {NUM_OPS{64'hDEAD_DEAD_DEAD_DEAD}};
    step();
    issue_i = 1'b0; zero_op_i = 1'b0; imm_valid_i = 1'b0; imm_data_i = '0; go_i = '0;
  endtask

  task automatic do_go(input int k, input logic [DATA_W-1:0] v);
    go_i = '0; go_i[k] = 1'b1;
    src_data_i = '0; src_data_i[k*DATA_W +: DATA_W] = v;
    step();
    go_i = '0; src_data_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 req", req_o, 0);
    chk("R1 ready", all_ready_o, 0);
    chk("R1 op0", op(0), 0);
    chk("R1 op1", op(1), 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 req idle", req_o, 0);
    end
    do_go(0, 64'h1111);
    chk("R7 stray op0", op(0), 0);
    chk("R2 ready idle", all_ready_o, 0);
  endtask

  task automatic t_basic();
    do_issue(1'b0, 1'b0, '0, '0);
    chk("R3 req both", req_o, 2'b11);
    chk("R8 not ready", all_ready_o, 0);
    do_go(1, 64'hBBBB_0000_0000_0001);
    chk("R6 req1 drop", req_o, 2'b01);
    chk("R6 op1", op(1), 64'hBBBB_0000_0000_0001);
    do_go(1, 64'h9999);
    chk("R7 op1 kept", op(1), 64'hBBBB_0000_0000_0001);
    chk("R7 req kept", req_o, 2'b01);
    do_go(0, 64'hAAAA_0000_0000_0002);
    chk("R6 op0", op(0), 64'hAAAA_0000_0000_0002);
    chk("R8 ready", all_ready_o, 1);
    chk("R8 req zero", req_o, 0);
  endtask

  task automatic t_zero();
    do_issue(1'b1, 1'b0, '0, '0);
    chk("R4 req", req_o, 2'b10);
    chk("R4 op0", op(0), 0);
    chk("R8 cleared", all_ready_o, 0);
    do_go(1, 64'hC0C0);
    chk("R6 op1", op(1), 64'hC0C0);
    chk("R8 ready zero", all_ready_o, 1);
  endtask

  task automatic t_imm();
    do_issue(1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, '0);
    chk("R5 req", req_o, 2'b01);
    chk("R5 op1", op(1), 64'h1234_5678_9ABC_DEF0);
    do_go(0, 64'h0F0F);
    chk("R6 op0", op(0), 64'h0F0F);
    chk("R8 ready imm", all_ready_o, 1);
  endtask

  task automatic t_both();
    do_issue(1'b1, 1'b1, 64'h5555, '0);
    chk("R4 both req", req_o, 0);
    chk("R4 op0", op(0), 0);
    chk("R5 op1", op(1), 64'h5555);
    chk("R8 ready at once", all_ready_o, 1);
  endtask

  task automatic t_restart();
    do_issue(1'b0, 1'b0, '0, '0);
    do_go(0, 64'h7777);
    chk("R6 half", req_o, 2'b10);
    do_issue(1'b0, 1'b0, '0, 2'b10);
    chk("R9 restart req", req_o, 2'b11);
    chk("R9 go ignored", op(1) == 64'hDEAD_DEAD_DEAD_DEAD, 0);
    chk("R9 ready", all_ready_o, 0);
  endtask

  initial begin
    rst = 1'b1; issue_i = 0; zero_op_i = 0; imm_valid_i = 0;
    imm_data_i = '0; go_i = '0; src_data_i = '0;
    step(); step();
    rst = 1'b0;
    t_reset();
    t_idle();
    t_basic();
    t_zero();
    t_imm();
    t_both();
    t_restart();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule